// File: doc/BRIEF.md
# Multidrop Serial Receive Address Filter

This block sits behind a serial receiver on a shared bus with one master and many slaves. It takes each frame once the receiver has already turned it into parallel form. It then decides whether that frame should raise the receive flag. A frame carries a byte, a ninth bit and a stop bit. In the nine-bit frame format, the ninth bit marks address frames. In the eight-bit format, the ninth-bit input carries the stop bit instead.

When address-only reception is enabled, the block accepts a frame only if its marker bit is high and its byte hits one of two addresses:
- The given address. This is the slave address register compared only at the positions where the mask register holds a one.
- The broadcast address. This is the OR of the address and mask registers. Every one bit in it must be received as one.

Once addressed, software drops the enable so that the following data frames pass. A bad stop bit sets a sticky framing-error flag, and only software clears it. Both registers reset to zero. With both at zero, every address frame hits.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset, ri_set, ri_flag, fe_flag, rx_data and rx_nine are 0, and both the address and mask registers hold 0.
- R2: With addr_only low, a frame whose stop is good raises ri_set for exactly the cycle after frame_vld, whatever its byte or ninth bit. The stop is good when rx_stop=1 with mode_9bit=1, or when rx_bit9=1 with mode_9bit=0. A frame with a bad stop raises no ri_set.
- R3: With addr_only high, a frame with rx_bit9=0 is ignored: no ri_set, and rx_data keeps its previous value.
- R4: Given match: with addr_only high and rx_bit9=1, a byte is accepted when it equals the address register at every bit where the mask register is 1. Bits where the mask is 0 are ignored.
- R5: Broadcast match: a byte is also accepted when it holds a 1 at every bit set in (address OR mask). Zero bits of that OR are ignored.
- R6: In eight-bit format (mode_9bit=0) with addr_only high, ri_set requires the stop bit (rx_bit9) to be 1 and the byte to match per R4 or R5.
- R7: With both registers at their reset value 00h, every frame with addr_only high and rx_bit9=1 is accepted.
- R8: fe_flag is set the cycle after any frame with a bad stop. Later good frames leave it set. fe_clr clears it. A bad stop in the same cycle as fe_clr leaves it set.
- R9: ri_flag is set with every ri_set pulse and stays set until ri_clr. A set in the same cycle as ri_clr wins.
- R10: On an accepted frame, rx_data and rx_nine take the frame's byte and ninth bit, and they are valid in the same cycle as ri_set. Rejected frames leave them unchanged.
- R11: With address A4h and mask FAh, bytes A0h and A1h are accepted as address frames, and A3h is rejected.
- R12: Lowering addr_only between frames applies to the very next frame, so a data frame with rx_bit9=0 is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr_we | input | 1 | Write strobe for the slave address register |
| cfg_mask_we | input | 1 | Write strobe for the mask register |
| cfg_wdata | input | DATA_W | Register write data |
| frame_vld | input | 1 | One-cycle strobe: a received frame is present |
| frame_byte | input | DATA_W | Received byte |
| rx_bit9 | input | 1 | Ninth bit (nine-bit format) or stop bit (eight-bit format) |
| rx_stop | input | 1 | Stop bit in nine-bit format |
| mode_9bit | input | 1 | 1 = nine-bit format, 0 = eight-bit format |
| addr_only | input | 1 | Address-only reception enable |
| ri_clr | input | 1 | Software clear of ri_flag |
| fe_clr | input | 1 | Software clear of fe_flag |
| ri_set | output | 1 | One-cycle receive-flag set pulse |
| ri_flag | output | 1 | Sticky receive flag |
| fe_flag | output | 1 | Sticky framing-error flag |
| rx_data | output | DATA_W | Byte of the last accepted frame |
| rx_nine | output | 1 | Ninth bit of the last accepted frame |

## Verification
A wrong bit in the address or mask register, or a faulty comparator lane, shows up within one cycle of the first frame. That frame is either accepted when it should be dropped, or dropped when it should be accepted. So sweeping every byte against several address and mask pairs exposes any lane error at once. A corrupted sticky flag shows on fe_flag or ri_flag in the cycle after the offending frame or clear. A stuck capture register shows as rx_data disagreeing with the byte of the most recently accepted frame.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

   typedef enum logic {
      FMT_EIGHT = 1'b0,
      FMT_NINE  = 1'b1
   } frame_fmt_e;

   typedef struct packed {
      logic given;
      logic bcast;
   } hit_t;

endpackage

// File: rtl/mpf_cfg_regs.sv
module mpf_cfg_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] mask_q
);

   localparam logic [DATA_W-1:0] RST_VAL = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= RST_VAL;
      end else if (addr_we) begin
         addr_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= RST_VAL;
      end else if (mask_we) begin
         mask_q <= wdata;
      end
   end

endmodule

// File: rtl/mpf_match.sv
module mpf_match
   import mpf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic [DATA_W-1:0] addr_i,
   input  logic [DATA_W-1:0] mask_i,
   output hit_t              hit_o
);

   logic [DATA_W-1:0] given_lane;
   logic [DATA_W-1:0] bcast_lane;

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      // a lane passes when masked off or when the bit agrees
      assign given_lane[i] = ~mask_i[i] | ~(byte_i[i] ^ addr_i[i]);
   end

   if (BCAST_EN) begin : g_bcast
      logic [DATA_W-1:0] bc_addr;
      assign bc_addr = addr_i | mask_i;
      for (genvar i = 0; i < DATA_W; i++) begin : g_blane
         assign bcast_lane[i] = ~bc_addr[i] | byte_i[i];
      end
      assign hit_o.bcast = &bcast_lane;
   end else begin : g_nobcast
      assign bcast_lane  = '0;
      assign hit_o.bcast = 1'b0;
   end

   assign hit_o.given = &given_lane;

endmodule

// File: rtl/mpf_flag.sv
module mpf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
      end else if (set_i) begin
         flag_o <= 1'b1;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end
   end

endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
   import mpf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_addr_we,
   input  logic              cfg_mask_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              frame_vld,
   input  logic [DATA_W-1:0] frame_byte,
   input  logic              rx_bit9,
   input  logic              rx_stop,
   input  logic              mode_9bit,
   input  logic              addr_only,
   input  logic              ri_clr,
   input  logic              fe_clr,
   output logic              ri_set,
   output logic              ri_flag,
   output logic              fe_flag,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_nine
);

   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
      $error("mp_addr_filter: DATA_W must lie in 2..32");
   end

   localparam logic [DATA_W-1:0] DATA_RST = '0;

   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] mask_q;
   hit_t              hit;
   frame_fmt_e        fmt;
   logic              stop_good;
   logic              addr_hit;
   logic              accept;
   logic              fe_set;
   logic              ri_q;

   mpf_cfg_regs #(.DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_we (cfg_addr_we),
      .mask_we (cfg_mask_we),
      .wdata   (cfg_wdata),
      .addr_q  (addr_q),
      .mask_q  (mask_q)
   );

   mpf_match #(.DATA_W(DATA_W), .BCAST_EN(BCAST_EN)) u_match (
      .byte_i (frame_byte),
      .addr_i (addr_q),
      .mask_i (mask_q),
      .hit_o  (hit)
   );

   assign fmt       = frame_fmt_e'(mode_9bit);
   assign stop_good = (fmt == FMT_NINE) ? rx_stop : rx_bit9;
   assign addr_hit  = hit.given | hit.bcast;

   // with filtering on, the ninth-bit input is the marker in nine-bit
   // format and the stop bit in eight-bit format: both must be 1
   always_comb begin
      if (!frame_vld) begin
         accept = 1'b0;
      end else if (addr_only) begin
         accept = rx_bit9 & addr_hit;
      end else begin
         accept = stop_good;
      end
   end

   assign fe_set = frame_vld & ~stop_good;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ri_q    <= 1'b0;
         rx_data <= DATA_RST;
         rx_nine <= 1'b0;
      end else begin
         ri_q <= accept;
         if (accept) begin
            rx_data <= frame_byte;
            rx_nine <= rx_bit9;
         end
      end
   end

   assign ri_set = ri_q;

   mpf_flag u_ri_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (accept),
      .clr_i  (ri_clr),
      .flag_o (ri_flag)
   );

   mpf_flag u_fe_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (fe_set),
      .clr_i  (fe_clr),
      .flag_o (fe_flag)
   );

endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_vld,
   input logic              rx_bit9,
   input logic              rx_stop,
   input logic              mode_9bit,
   input logic              addr_only,
   input logic              fe_clr,
   input logic              ri_set,
   input logic              ri_flag,
   input logic              fe_flag,
   input logic [DATA_W-1:0] rx_data
);

   logic stop_ok;
   assign stop_ok = mode_9bit ? rx_stop : rx_bit9;

   p_open_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld && !addr_only && stop_ok |=> ri_set);

   p_data_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld && addr_only && !rx_bit9 |=> !ri_set);

   p_fe_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld && !stop_ok |=> fe_flag);

   p_fe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fe_flag && !fe_clr |=> fe_flag);

   p_fe_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fe_flag && fe_clr && !(frame_vld && !stop_ok) |=> !fe_flag);

   p_ri_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ri_set |-> ri_flag);

   p_ri_from_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ri_set |-> $past(frame_vld));

   p_data_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ri_set |-> $stable(rx_data));

endmodule

bind mp_addr_filter mpf_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_vld (frame_vld),
   .rx_bit9   (rx_bit9),
   .rx_stop   (rx_stop),
   .mode_9bit (mode_9bit),
   .addr_only (addr_only),
   .fe_clr    (fe_clr),
   .ri_set    (ri_set),
   .ri_flag   (ri_flag),
   .fe_flag   (fe_flag),
   .rx_data   (rx_data)
);

// File: tb/mp_addr_filter_test.sv
module mp_addr_filter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_addr_we = 1'b0;
   logic       cfg_mask_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       frame_vld = 1'b0;
   logic [7:0] frame_byte = 8'h00;
   logic       rx_bit9 = 1'b0;
   logic       rx_stop = 1'b1;
   logic       mode_9bit = 1'b1;
   logic       addr_only = 1'b0;
   logic       ri_clr = 1'b0;
   logic       fe_clr = 1'b0;
   logic       ri_set, ri_flag, fe_flag, rx_nine;
   logic [7:0] rx_data;

   int total = 0;
   int fails = 0;
   logic [7:0] last_acc = 8'h00;

   always #5 clk = ~clk;

   mp_addr_filter #(.DATA_W(8), .BCAST_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_addr_we(cfg_addr_we), .cfg_mask_we(cfg_mask_we),
      .cfg_wdata(cfg_wdata), .frame_vld(frame_vld), .frame_byte(frame_byte),
      .rx_bit9(rx_bit9), .rx_stop(rx_stop), .mode_9bit(mode_9bit),
      .addr_only(addr_only), .ri_clr(ri_clr), .fe_clr(fe_clr), .ri_set(ri_set),
      .ri_flag(ri_flag), .fe_flag(fe_flag), .rx_data(rx_data), .rx_nine(rx_nine)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit given_hit(input int b, input int a, input int m);
      return ((b ^ a) & m & 8'hFF) == 0;
   endfunction

   function automatic bit bcast_hit(input int b, input int a, input int m);
      return ((~b) & (a | m) & 8'hFF) == 0;
   endfunction

   task automatic cfg(input int a, input int m);
      @(negedge clk); cfg_addr_we = 1'b1; cfg_wdata = 8'(a);
      @(negedge clk); cfg_addr_we = 1'b0; cfg_mask_we = 1'b1; cfg_wdata = 8'(m);
      @(negedge clk); cfg_mask_we = 1'b0;
   endtask

   // drive one frame; on return the registered outputs of that frame are visible
   task automatic send(input int b, input bit n, input bit s);
      @(negedge clk);
      frame_byte = 8'(b); rx_bit9 = n; rx_stop = s; frame_vld = 1'b1;
      @(negedge clk);
      frame_vld = 1'b0;
   endtask

   task automatic sweep9(input int a, input int m);
      for (int b = 0; b < 256; b++) begin
         for (int n = 0; n < 2; n++) begin
            bit exp;
            string tag;
            send(b, n[0], 1'b1);
            exp = (n == 1) && (given_hit(b, a, m) || bcast_hit(b, a, m));
            if (n == 0) tag = "R3";
            else if (given_hit(b, a, m)) tag = "R4";
            else if (bcast_hit(b, a, m)) tag = "R5";
            else tag = "R4/R5 reject";
            chk(ri_set == exp, tag, int'(ri_set), int'(exp));
            if (exp) last_acc = 8'(b);
            chk(rx_data == last_acc, "R10", int'(rx_data), int'(last_acc));
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ri_set == 1'b0, "R1", int'(ri_set), 0);
      chk(ri_flag == 1'b0, "R1", int'(ri_flag), 0);
      chk(fe_flag == 1'b0, "R1", int'(fe_flag), 0);
      chk(rx_data == 8'h00 && rx_nine == 1'b0, "R1", int'(rx_data), 0);

      // reset registers 00h/00h: every address frame passes
      addr_only = 1'b1; mode_9bit = 1'b1;
      for (int b = 0; b < 256; b++) begin
         send(b, 1'b1, 1'b1);
         chk(ri_set == 1'b1, "R7", int'(ri_set), 1);
         chk(rx_data == 8'(b) && rx_nine == 1'b1, "R10", int'(rx_data), b);
      end
      last_acc = 8'hFF;

      // masked sweeps in nine-bit format
      cfg(8'hA4, 8'hFA); sweep9(8'hA4, 8'hFA);
      cfg(8'hA7, 8'hF9); sweep9(8'hA7, 8'hF9);
      cfg(8'h3C, 8'h0F); sweep9(8'h3C, 8'h0F);
      cfg(8'h00, 8'hFF); sweep9(8'h00, 8'hFF);

      // worked example
      cfg(8'hA4, 8'hFA);
      send(8'hA0, 1'b1, 1'b1); chk(ri_set == 1'b1, "R11 A0", int'(ri_set), 1);
      send(8'hA1, 1'b1, 1'b1); chk(ri_set == 1'b1, "R11 A1", int'(ri_set), 1);
      send(8'hA3, 1'b1, 1'b1); chk(ri_set == 1'b0, "R11 A3", int'(ri_set), 0);
      last_acc = 8'hA1;

      // eight-bit format: ninth input is the stop bit
      mode_9bit = 1'b0;
      cfg(8'h5A, 8'hF0);
      for (int b = 0; b < 256; b++) begin
         for (int s = 0; s < 2; s++) begin
            bit exp;
            send(b, s[0], 1'b0);
            exp = (s == 1) && (given_hit(b, 8'h5A, 8'hF0) || bcast_hit(b, 8'h5A, 8'hF0));
            chk(ri_set == exp, "R6", int'(ri_set), int'(exp));
         end
      end
      @(negedge clk); fe_clr = 1'b1; @(negedge clk); fe_clr = 1'b0;
      chk(fe_flag == 1'b0, "R8 clear", int'(fe_flag), 0);

      // filtering off
      addr_only = 1'b0;
      send(8'h13, 1'b1, 1'b0);
      chk(ri_set == 1'b1, "R2 eight-bit good stop", int'(ri_set), 1);
      send(8'h14, 1'b0, 1'b1);
      chk(ri_set == 1'b0, "R2 eight-bit bad stop", int'(ri_set), 0);
      chk(fe_flag == 1'b1, "R8 set", int'(fe_flag), 1);
      mode_9bit = 1'b1;
      send(8'h77, 1'b0, 1'b1);
      chk(ri_set == 1'b1 && rx_data == 8'h77, "R2 nine-bit data frame", int'(rx_data), 8'h77);
      send(8'h78, 1'b1, 1'b0);
      chk(ri_set == 1'b0, "R2 nine-bit bad stop", int'(ri_set), 0);
      send(8'h79, 1'b0, 1'b1);
      chk(fe_flag == 1'b1, "R8 sticky after good frame", int'(fe_flag), 1);
      // bad stop together with clear: set wins
      @(negedge clk);
      frame_byte = 8'h01; rx_bit9 = 1'b0; rx_stop = 1'b0; frame_vld = 1'b1; fe_clr = 1'b1;
      @(negedge clk); frame_vld = 1'b0; fe_clr = 1'b0;
      chk(fe_flag == 1'b1, "R8 set beats clear", int'(fe_flag), 1);
      @(negedge clk); fe_clr = 1'b1; @(negedge clk); fe_clr = 1'b0;
      chk(fe_flag == 1'b0, "R8 clear", int'(fe_flag), 0);

      // receive flag
      chk(ri_flag == 1'b1, "R9 sticky", int'(ri_flag), 1);
      @(negedge clk); ri_clr = 1'b1; @(negedge clk); ri_clr = 1'b0;
      chk(ri_flag == 1'b0, "R9 clear", int'(ri_flag), 0);
      @(negedge clk);
      frame_byte = 8'h42; rx_bit9 = 1'b0; rx_stop = 1'b1; frame_vld = 1'b1; ri_clr = 1'b1;
      @(negedge clk); frame_vld = 1'b0; ri_clr = 1'b0;
      chk(ri_flag == 1'b1, "R9 set beats clear", int'(ri_flag), 1);

      // addressed, then enable dropped
      addr_only = 1'b1;
      cfg(8'hA4, 8'hFA);
      send(8'h55, 1'b0, 1'b1);
      chk(ri_set == 1'b0 && rx_data == 8'h42, "R3 ignored keeps data", int'(rx_data), 8'h42);
      send(8'hA0, 1'b1, 1'b1);
      chk(ri_set == 1'b1 && rx_nine == 1'b1, "R12 addressed", int'(ri_set), 1);
      addr_only = 1'b0;
      send(8'h66, 1'b0, 1'b1);
      chk(ri_set == 1'b1 && rx_data == 8'h66 && rx_nine == 1'b0, "R12 data accepted",
          int'(rx_data), 8'h66);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule